// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a 32-pin general-purpose I/O bank that software drives through a small synchronous register bus. Each pin has a direction bit. The output latch changes only through two registers: one sets bits and the other clears them, and a 1 in the written mask selects the pin. This lets several agents change different pins without a read-modify-write race. Pad inputs pass through a two-flop synchronizer. The synchronized levels feed both the input readback register and the edge detectors.

Rising and falling edge detection are enabled per pin through their own set and clear registers. A detected edge on an enabled pin latches a bit in a write-one-to-clear status register. The pins form two 16-pin interrupt groups. Each group raises a level interrupt line while any of its status bits is pending and its bit in the group-enable register is 1.

The bus reads combinationally: read data is valid in the same cycle as the address. A write takes effect at the clock edge that samples it. Byte offsets are word aligned.

Top module: `gpio_bank`

## Requirements
- R1: The direction register (offset 0x00) holds one bit per pin. A bit of 1 makes the pin an input (`pad_oe` bit low). A bit of 0 makes it an output (`pad_oe` bit high).
- R2: Writing a mask to offset 0x0C sets the masked bits of the output latch to 1 and leaves the other bits unchanged. The latch drives `pad_out` and reads back at offset 0x04.
- R3: Writing a mask to offset 0x10 clears the masked bits of the output latch to 0 and leaves the other bits unchanged.
- R4: Offset 0x14 returns the level of every pin after two clock edges of synchronization, whatever the pin's direction. A read in the same cycle as a pad change, or one cycle after it, still returns the old level.
- R5: The rising-edge enables are set by a mask written to 0x18 and cleared by a mask written to 0x1C. The falling-edge enables are set through 0x20 and cleared through 0x24. Each of these offsets reads back the current enable mask of its kind.
- R6: A pad transition on a pin whose matching edge is enabled sets the pin's bit in the status register (0x28) at the third clock edge after the change. Transitions whose edge is not enabled leave the status unchanged. A pin with both enables catches both directions.
- R7: Writing 1s to 0x28 clears those status bits, and bits written as 0 stay as they are. If a new edge and a clear hit the same bit in the same cycle, the bit stays set.
- R8: The group-enable register sits at offset 0x08; bit 0 controls pins 0–15 and bit 1 controls pins 16–31. `irq[g]` is high exactly while group g has a pending status bit and its enable bit is 1.
- R9: After reset, all direction bits are 1 and the output latch is 0. Both edge-enable masks, the status register and the group-enable register are also 0.
- R10: Writes to the read-only offsets 0x04 and 0x14 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data / mask |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output latch value |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 2 | Per-group level interrupt lines |

## Verification
The assertions assume that `pad_in` is low while reset is held. A high pad during reset would show up as a rising edge once reset drops. They also assume that only one register is written per cycle, which the bus provides by construction. The stimulus holds the pads at zero through reset. It changes the pads only at falling clock edges and then waits at least four cycles before it checks the status register, so every edge has fully passed through the synchronizer. Random masks, enables and pad patterns come from a seeded generator. Directed cases cover the synchronizer latency and a clear that collides with a new edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned ADDR_W = 6;

    typedef enum logic [3:0] {
        REG_DIR     = 4'd0,
        REG_OUT     = 4'd1,
        REG_GRPEN   = 4'd2,
        REG_OUTSET  = 4'd3,
        REG_OUTCLR  = 4'd4,
        REG_IN      = 4'd5,
        REG_RISESET = 4'd6,
        REG_RISECLR = 4'd7,
        REG_FALLSET = 4'd8,
        REG_FALLCLR = 4'd9,
        REG_STAT    = 4'd10,
        REG_NONE    = 4'd15
    } reg_sel_e;

    // Set/clear strobe pair for one mask register
    typedef struct packed {
        logic set_w;
        logic clr_w;
    } mask_strobe_t;

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00 || a[ADDR_W-1:2] > 4'd10) return REG_NONE;
        return reg_sel_e'(a[ADDR_W-1:2]);
    endfunction

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~prev_q;
    assign fall  = ~sync_q & prev_q;

    // R6: a pin cannot show a rising edge on two consecutive cycles
    p_edge_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/gpio_wmask_reg.sv
module gpio_wmask_reg #(
    parameter int unsigned W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  gpio_bank_pkg::mask_strobe_t  strb,
    input  logic [W-1:0]                 mask,
    output logic [W-1:0]                 q
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst)              q_r <= '0;
        else if (strb.set_w)  q_r <= q_r | mask;
        else if (strb.clr_w)  q_r <= q_r & ~mask;
    end

    assign q = q_r;

    // R2: a set mask forces its bits high
    p_set_high_r2: assert property (@(posedge clk) disable iff (rst)
        strb.set_w |=> ((q & $past(mask)) == $past(mask)));

    // R3: a clear mask forces its bits low
    p_clr_low_r3: assert property (@(posedge clk) disable iff (rst)
        (strb.clr_w && !strb.set_w) |=> ((q & $past(mask)) == '0));

    // R2/R5: bits outside the written mask keep their value
    p_unmasked_hold_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((q ^ $past(q)) &
                   ~(($past(strb.set_w) || $past(strb.clr_w)) ? $past(mask) : '0)) == '0));

endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
    parameter int unsigned GW = 16
) (
    input  logic [GW-1:0] pend,
    input  logic          en,
    output logic          irq
);
    assign irq = en & (|pend);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter  int unsigned NPINS   = 32,
    parameter  int unsigned GROUP_W = 16,
    localparam int unsigned NGROUPS = NPINS / GROUP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NPINS-1:0]   bus_wdata,
    output logic [NPINS-1:0]   bus_rdata,
    input  logic [NPINS-1:0]   pad_in,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NGROUPS-1:0] irq
);
    localparam int unsigned NMASK = 3;  // output latch, rise enable, fall enable

    reg_sel_e sel;
    logic     we;
    assign sel = decode_addr(bus_addr);
    assign we  = bus_sel & bus_wr;

    // Direction and group enable
    logic [NPINS-1:0]   dir_q;
    logic [NGROUPS-1:0] grp_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q    <= '1;
            grp_en_q <= '0;
        end else if (we) begin
            if (sel == REG_DIR)   dir_q    <= bus_wdata;
            if (sel == REG_GRPEN) grp_en_q <= bus_wdata[NGROUPS-1:0];
        end
    end

    // Set/clear mask registers
    mask_strobe_t     strb [NMASK];
    logic [NPINS-1:0] mq   [NMASK];

    assign strb[0] = '{set_w: we && sel == REG_OUTSET,  clr_w: we && sel == REG_OUTCLR};
    assign strb[1] = '{set_w: we && sel == REG_RISESET, clr_w: we && sel == REG_RISECLR};
    assign strb[2] = '{set_w: we && sel == REG_FALLSET, clr_w: we && sel == REG_FALLCLR};

    for (genvar k = 0; k < NMASK; k++) begin : g_mask
        gpio_wmask_reg #(.W(NPINS)) u_mask (
            .clk  (clk),
            .rst  (rst),
            .strb (strb[k]),
            .mask (bus_wdata),
            .q    (mq[k])
        );
    end

    logic [NPINS-1:0] out_q, rise_en, fall_en;
    assign out_q   = mq[0];
    assign rise_en = mq[1];
    assign fall_en = mq[2];

    // Synchronizer and edge detect
    logic [NPINS-1:0] lvl, rise, fall;
    gpio_edge_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pad   (pad_in),
        .level (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    // Status: new edges win over a same-cycle clear
    logic [NPINS-1:0] events, stat_clr, stat_q;
    assign events   = (rise & rise_en) | (fall & fall_en);
    assign stat_clr = (we && sel == REG_STAT) ? bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~stat_clr) | events;
    end

    // Interrupt groups
    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        gpio_irq_group #(.GW(GROUP_W)) u_grp (
            .pend (stat_q[g*GROUP_W +: GROUP_W]),
            .en   (grp_en_q[g]),
            .irq  (irq[g])
        );
    end

    assign pad_out = out_q;
    assign pad_oe  = ~dir_q;

    always_comb begin
        unique case (sel)
            REG_DIR:                  bus_rdata = dir_q;
            REG_OUT, REG_OUTSET,
            REG_OUTCLR:               bus_rdata = out_q;
            REG_GRPEN:                bus_rdata = {{(NPINS-NGROUPS){1'b0}}, grp_en_q};
            REG_IN:                   bus_rdata = lvl;
            REG_RISESET, REG_RISECLR: bus_rdata = rise_en;
            REG_FALLSET, REG_FALLCLR: bus_rdata = fall_en;
            REG_STAT:                 bus_rdata = stat_q;
            default:                  bus_rdata = '0;
        endcase
    end

    // R7: an enabled edge always lands in status, even during a clear
    p_edge_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (events != '0) |=> ((stat_q & $past(events)) == $past(events)));

    // R7: cleared bits without a new edge are zero afterwards
    p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
        (we && sel == REG_STAT) |=> ((stat_q & $past(bus_wdata) & ~$past(events)) == '0));

    // R8: disabling all groups silences every line
    p_grp_off_r8: assert property (@(posedge clk) disable iff (rst)
        (we && sel == REG_GRPEN && bus_wdata[NGROUPS-1:0] == '0) |=> (irq == '0));

    // R10: read-only offsets leave direction and latch alone
    p_ro_write_r10: assert property (@(posedge clk) disable iff (rst)
        (we && (sel == REG_OUT || sel == REG_IN)) |=> ($stable(dir_q) && $stable(out_q)));

endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
    logic [1:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_bank dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    localparam logic [5:0] A_DIR = 6'h00, A_OUT = 6'h04, A_GRP = 6'h08,
        A_OSET = 6'h0C, A_OCLR = 6'h10, A_IN = 6'h14, A_RSET = 6'h18,
        A_RCLR = 6'h1C, A_FSET = 6'h20, A_FCLR = 6'h24, A_STAT = 6'h28;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [1:0] exp_irq(logic [31:0] st, logic [1:0] en);
        return {en[1] & (|st[31:16]), en[0] & (|st[15:0])};
    endfunction

    function automatic logic [31:0] exp_stat(logic [31:0] old_p, logic [31:0] new_p,
                                             logic [31:0] re, logic [31:0] fe);
        return ((new_p & ~old_p) & re) | ((old_p & ~new_p) & fe);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, m_out, m_dir, re, fe, oldp, newp, st;
        logic [1:0]  ge;
        void'($urandom(32'h5EED_1234));
        rst = 1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; pad_in = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R9 reset state
        rd(A_DIR, d);  chk("R9 dir", d, 32'hFFFF_FFFF);
        rd(A_OUT, d);  chk("R9 out", d, 32'h0);
        rd(A_RSET, d); chk("R9 rise_en", d, 32'h0);
        rd(A_FSET, d); chk("R9 fall_en", d, 32'h0);
        rd(A_STAT, d); chk("R9 stat", d, 32'h0);
        rd(A_GRP, d);  chk("R9 grpen", d, 32'h0);
        chk("R1 reset oe", pad_oe, 32'h0);

        // R1 direction
        wr(A_DIR, 32'h0000_FF0F);
        #1 chk("R1 oe", pad_oe, 32'hFFFF_00F0);

        // R2/R3 random set/clear against model
        m_out = 0;
        for (int i = 0; i < 20; i++) begin
            d = $urandom;
            if (i % 2 == 0) begin wr(A_OSET, d); m_out = m_out | d;  end
            else            begin wr(A_OCLR, d); m_out = m_out & ~d; end
            rd(A_OUT, st);
            chk(i % 2 == 0 ? "R2 set" : "R3 clear", st, m_out);
        end
        #1 chk("R2 pad_out", pad_out, m_out);

        // R10 read-only writes
        m_dir = 32'h0000_FF0F;
        wr(A_OUT, ~m_out);
        wr(A_IN, 32'hDEAD_BEEF);
        rd(A_OUT, d); chk("R10 out", d, m_out);
        rd(A_DIR, d); chk("R10 dir", d, m_dir);

        // R4 synchronizer latency, pins configured as outputs too
        wr(A_DIR, 32'h0);
        pad_in = 32'hA5A5_0F0F;
        rd(A_IN, d); chk("R4 same cycle", d, 32'h0);
        @(negedge clk); rd(A_IN, d); chk("R4 one edge", d, 32'h0);
        @(negedge clk); rd(A_IN, d); chk("R4 two edges", d, 32'hA5A5_0F0F);
        pad_in = 0;
        repeat (4) @(negedge clk);
        wr(A_STAT, 32'hFFFF_FFFF);

        // R5 enable set/clear readback
        wr(A_RSET, 32'h00FF_00FF); wr(A_RCLR, 32'h0000_000F);
        rd(A_RCLR, d); chk("R5 rise", d, 32'h00FF_00F0);
        wr(A_FSET, 32'h1234_5678); wr(A_FCLR, 32'h0000_0078);
        rd(A_FSET, d); chk("R5 fall", d, 32'h1234_5600);

        // R6/R8 random edge trials
        oldp = 0;
        for (int i = 0; i < 30; i++) begin
            re = $urandom; fe = $urandom; ge = 2'($urandom);
            wr(A_RSET, re); wr(A_RCLR, ~re);
            wr(A_FSET, fe); wr(A_FCLR, ~fe);
            wr(A_GRP, {30'd0, ge});
            wr(A_STAT, 32'hFFFF_FFFF);
            newp = $urandom;
            pad_in = newp;
            rd(A_STAT, d); chk("R6 not yet", d, 32'h0);
            repeat (2) @(negedge clk);
            rd(A_STAT, d); chk("R6 two edges", d, 32'h0);
            repeat (2) @(negedge clk);
            st = exp_stat(oldp, newp, re, fe);
            rd(A_STAT, d); chk("R6 status", d, st);
            chk("R8 irq", {30'd0, irq}, {30'd0, exp_irq(st, ge)});
            oldp = newp;
        end

        // R7 W1C and collision with a new edge
        wr(A_RSET, 32'hFFFF_FFFF); wr(A_FSET, 32'hFFFF_FFFF);
        pad_in = 0;
        repeat (4) @(negedge clk);
        wr(A_STAT, 32'hFFFF_FFFF);
        pad_in = 32'h0000_0028;
        repeat (4) @(negedge clk);
        rd(A_STAT, d); chk("R6 both edges rise", d, 32'h0000_0028);
        wr(A_STAT, 32'h0000_0008);
        rd(A_STAT, d); chk("R7 w1c partial", d, 32'h0000_0020);
        wr(A_STAT, 32'hFFFF_FFFF);
        @(negedge clk);
        pad_in = 32'h0000_0020;             // falling edge on pin 3
        @(negedge clk); @(negedge clk);     // event is now active
        bus_sel = 1; bus_wr = 1; bus_addr = A_STAT; bus_wdata = 32'h0000_0008;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        rd(A_STAT, d); chk("R7 edge wins", d, 32'h0000_0008);

        // R8 group gating
        wr(A_GRP, 2'b10); #1 chk("R8 grp1 only", {30'd0, irq}, 32'd0);
        wr(A_GRP, 2'b01); #1 chk("R8 grp0", {30'd0, irq}, 32'd1);
        wr(A_STAT, 32'h8); #1 chk("R8 cleared", {30'd0, irq}, 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule